// File: doc/BRIEF.md
# Hypervisor Control Register File

This block holds the 32-bit system control word for the hypervisor privilege level. It offers coprocessor-style access: a one-cycle read strobe and a one-cycle write strobe. Each access is judged against the current privilege level, the security state, whether the hypervisor level is enabled, and a trap-enable bit taken from a separate trap register. An access is then allowed, refused as an undefined instruction, or redirected to the hypervisor as a trap with a syndrome code. Reserved positions are pinned to their fixed values on every write. The commonly used fields are decoded onto dedicated output pins: translation enable, alignment checking, data and instruction caching, and endianness on entry.

Every access finishes in the cycle it is presented. The block never stalls, so the strobes carry no handshake and there is no back-pressure. A read returns data combinationally in the same cycle. An allowed write takes effect at the next rising clock edge. Two parameters choose whether the barrier-enable field and the IT-disable field exist. When a field is absent it is wired to its fixed value.

Top module: `hyp_ctrl_regfile`

## Requirements
- R1: Bits 29, 28, 23, 22, 18, 16 and 11 always read as 1. When `HAS_BARRIER_EN` is 0, bit 5 also reads as 1. Written values at these bits have no effect.
- R2: Bits 27, 26, 24, 21, 20, 17, 15, 14, 13, 10, 9 and 6 always read as 0. When `HAS_IT_DISABLE` is 0, bit 7 also reads as 0. Written values at these bits have no effect.
- R3: After reset, the word reads 0x30C5_0818 with both optional fields present, and 0x30C5_0838 with both absent. Bits 0, 2 and 12 are 0. Bits 3 and 4 are 1. All other writable bits are 0.
- R4: `level` is encoded as 0 = user, 1 = kernel, 2 = hypervisor, 3 = monitor. Any read or write from level 0 raises `undef_o` and does not raise `trap_o`.
- R5: An access from level 1 raises `trap_o` with `syndrome_o` = 0x03 when `hyp_enabled` and `trap_bit` are both 1. Otherwise it raises `undef_o`.
- R6: An access from level 2 is always allowed. A read returns the stored word in the same cycle. A write is visible from the next clock edge.
- R7: An access from level 3 raises `undef_o` when `nonsecure` is 0. It is allowed when `nonsecure` is 1.
- R8: Each optional field follows its own parameter. When the field is present, it stores the written bit.
- R9: A refused access (undefined or trapped) leaves the stored word unchanged, and `rd_data` reads 0. With no strobe active, neither flag is raised.
- R10: `mmu_en`, `align_chk`, `dcache_en`, `icache_en` and `big_endian` follow stored bits 0, 1, 2, 12 and 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level | input | 2 | Current privilege level |
| nonsecure | input | 1 | 1 when in the non-secure state |
| hyp_enabled | input | 1 | Hypervisor level is enabled |
| trap_bit | input | 1 | Trap-enable bit for this register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, 0 unless the read is allowed |
| undef_o | output | 1 | Access is an undefined instruction |
| trap_o | output | 1 | Access traps to the hypervisor |
| syndrome_o | output | SYN_W | Trap syndrome code |
| mmu_en | output | 1 | Translation enable (bit 0) |
| align_chk | output | 1 | Alignment checking (bit 1) |
| dcache_en | output | 1 | Data caching (bit 2) |
| icache_en | output | 1 | Instruction caching (bit 12) |
| big_endian | output | 1 | Endianness on entry (bit 25) |

## Verification
The assertions assume that the strobes and the privilege inputs change only between clock edges. They also assume that a write's effect is observed on the cycle after the strobe. The bench meets both conditions by driving every input at the falling edge and holding it for one full cycle.

The stimulus sweeps all 32 combinations of level, security state, hypervisor enable and trap bit. Between combinations it always returns to the hypervisor level to rewrite or read back the word. Because of this, each refused write is observed through an allowed read before the next stimulus arrives.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } priv_t;

  localparam logic [REG_W-1:0] FIX_ONE_BASE  = 32'h30C5_0800;
  localparam logic [REG_W-1:0] FIX_ZERO_BASE = 32'h0D32_E640;
  localparam logic [REG_W-1:0] LIVE_RESET    = 32'h0000_0018;
  localparam int BARRIER_BIT = 5;
  localparam int ITDIS_BIT   = 7;
  localparam int TRAP_CODE   = 3;

  function automatic logic [REG_W-1:0] ones_mask(input bit has_barrier);
    logic [REG_W-1:0] m;
    m = FIX_ONE_BASE;
    if (!has_barrier) m[BARRIER_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] zeros_mask(input bit has_itdis);
    logic [REG_W-1:0] m;
    m = FIX_ZERO_BASE;
    if (!has_itdis) m[ITDIS_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hcr_access_gate.sv
module hcr_access_gate
  import hcr_pkg::*;
#(
  parameter int SYN_W = 6
) (
  input  logic [1:0]       level,
  input  logic             nonsecure,
  input  logic             hyp_enabled,
  input  logic             trap_bit,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic             undef,
  output logic             trap,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [SYN_W-1:0] syndrome
);
  logic  access;
  logic  deny, redirect;
  priv_t lvl;

  always_comb begin
    lvl      = priv_t'(level);
    access   = wr_en | rd_en;
    deny     = 1'b0;
    redirect = 1'b0;
    unique case (lvl)
      LVL_USER:   deny = 1'b1;
      LVL_KERNEL: begin
        redirect = hyp_enabled & trap_bit;
        deny     = ~redirect;
      end
      LVL_HYP:    deny = 1'b0;
      LVL_MON:    deny = ~nonsecure;
      default:    deny = 1'b1;
    endcase
    undef    = access & deny;
    trap     = access & redirect;
    wr_ok    = wr_en & ~deny & ~redirect;
    rd_ok    = rd_en & ~deny & ~redirect;
    syndrome = trap ? SYN_W'(TRAP_CODE) : '0;
  end
endmodule

// File: rtl/hcr_field_store.sv
module hcr_field_store
  import hcr_pkg::*;
#(
  parameter logic [REG_W-1:0] FIX_ONES  = FIX_ONE_BASE,
  parameter logic [REG_W-1:0] FIX_ZEROS = FIX_ZERO_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] LIVE  = ~(FIX_ONES | FIX_ZEROS);
  localparam logic [REG_W-1:0] RST_V = FIX_ONES | (LIVE_RESET & LIVE);

  logic [REG_W-1:0] shaped;
  assign shaped = (wr_data & LIVE) | FIX_ONES;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (LIVE[b]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)     q[b] <= RST_V[b];
        else if (wr_ok) q[b] <= shaped[b];
      end
    end else begin : g_fixed
      assign q[b] = shaped[b];
    end
  end
endmodule

// File: rtl/hcr_ctl_decode.sv
module hcr_ctl_decode
  import hcr_pkg::*;
(
  input  logic [REG_W-1:0] q,
  input  logic             rd_ok,
  output logic [REG_W-1:0] rd_data,
  output logic             mmu_en,
  output logic             align_chk,
  output logic             dcache_en,
  output logic             icache_en,
  output logic             big_endian
);
  assign rd_data    = rd_ok ? q : '0;
  assign mmu_en     = q[0];
  assign align_chk  = q[1];
  assign dcache_en  = q[2];
  assign icache_en  = q[12];
  assign big_endian = q[25];
endmodule

// File: rtl/hyp_ctrl_regfile.sv
module hyp_ctrl_regfile
  import hcr_pkg::*;
#(
  parameter bit HAS_BARRIER_EN = 1'b1,
  parameter bit HAS_IT_DISABLE = 1'b1,
  parameter int SYN_W          = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       level,
  input  logic             nonsecure,
  input  logic             hyp_enabled,
  input  logic             trap_bit,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             undef_o,
  output logic             trap_o,
  output logic [SYN_W-1:0] syndrome_o,
  output logic             mmu_en,
  output logic             align_chk,
  output logic             dcache_en,
  output logic             icache_en,
  output logic             big_endian
);
  localparam logic [REG_W-1:0] ONES  = ones_mask(HAS_BARRIER_EN);
  localparam logic [REG_W-1:0] ZEROS = zeros_mask(HAS_IT_DISABLE);

  logic             wr_ok, rd_ok;
  logic [REG_W-1:0] word_q;

  hcr_access_gate #(.SYN_W(SYN_W)) u_gate (
    .level       (level),
    .nonsecure   (nonsecure),
    .hyp_enabled (hyp_enabled),
    .trap_bit    (trap_bit),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .undef       (undef_o),
    .trap        (trap_o),
    .wr_ok       (wr_ok),
    .rd_ok       (rd_ok),
    .syndrome    (syndrome_o)
  );

  hcr_field_store #(.FIX_ONES(ONES), .FIX_ZEROS(ZEROS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok),
    .wr_data (wr_data),
    .q       (word_q)
  );

  hcr_ctl_decode u_dec (
    .q          (word_q),
    .rd_ok      (rd_ok),
    .rd_data    (rd_data),
    .mmu_en     (mmu_en),
    .align_chk  (align_chk),
    .dcache_en  (dcache_en),
    .icache_en  (icache_en),
    .big_endian (big_endian)
  );
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker
  import hcr_pkg::*;
#(
  parameter bit HAS_BARRIER_EN = 1'b1,
  parameter bit HAS_IT_DISABLE = 1'b1,
  parameter int SYN_W          = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       level,
  input logic             nonsecure,
  input logic             wr_en,
  input logic             rd_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             undef_o,
  input logic             trap_o,
  input logic [SYN_W-1:0] syndrome_o,
  input logic             mmu_en
);
  localparam logic [REG_W-1:0] ONES  = ones_mask(HAS_BARRIER_EN);
  localparam logic [REG_W-1:0] ZEROS = zeros_mask(HAS_IT_DISABLE);

  logic good_rd, good_wr, any_acc;
  assign any_acc = rd_en | wr_en;
  assign good_rd = rd_en & ~undef_o & ~trap_o;
  assign good_wr = wr_en & ~undef_o & ~trap_o;

  assert_fixed_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    good_rd |-> ((rd_data & ONES) == ONES));
  assert_fixed_zeros_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good_rd |-> ((rd_data & ZEROS) == '0));
  assert_user_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && level == 2'd0) |-> (undef_o && !trap_o));
  assert_trap_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (syndrome_o == SYN_W'(TRAP_CODE) && level == 2'd1 && !undef_o));
  assert_hyp_allowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && level == 2'd2) |-> (!undef_o && !trap_o));
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> (mmu_en == $past(wr_data[0])));
  assert_secure_mon_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && level == 2'd3 && !nonsecure) |-> undef_o);
  assert_refused_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (undef_o || trap_o)) |=> $stable(mmu_en));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_acc |-> (!undef_o && !trap_o && rd_data == '0));
endmodule

bind hyp_ctrl_regfile hcr_checker #(
  .HAS_BARRIER_EN (HAS_BARRIER_EN),
  .HAS_IT_DISABLE (HAS_IT_DISABLE),
  .SYN_W          (SYN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .level      (level),
  .nonsecure  (nonsecure),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .undef_o    (undef_o),
  .trap_o     (trap_o),
  .syndrome_o (syndrome_o),
  .mmu_en     (mmu_en)
);

// File: tb/sim_hyp_ctrl_regfile.sv
`timescale 1ns/1ps
module sim_hyp_ctrl_regfile;
  localparam logic [31:0] ONE_A  = 32'h30C5_0800;
  localparam logic [31:0] ZERO_A = 32'h0D32_E640;
  localparam logic [31:0] ONE_B  = ONE_A | 32'h20;
  localparam logic [31:0] ZERO_B = ZERO_A | 32'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] level = 2'd2;
  logic nonsecure = 1'b0, hyp_enabled = 1'b0, trap_bit = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0, rd1;
  logic und0, trp0, und1, trp1;
  logic [5:0] syn0, syn1;
  logic m0, a0, d0, i0, e0, m1, a1, d1, i1, e1;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hyp_ctrl_regfile u0 (
    .clk(clk), .rst_n(rst_n), .level(level), .nonsecure(nonsecure),
    .hyp_enabled(hyp_enabled), .trap_bit(trap_bit), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd0), .undef_o(und0), .trap_o(trp0),
    .syndrome_o(syn0), .mmu_en(m0), .align_chk(a0), .dcache_en(d0),
    .icache_en(i0), .big_endian(e0));

  hyp_ctrl_regfile #(.HAS_BARRIER_EN(1'b0), .HAS_IT_DISABLE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .level(level), .nonsecure(nonsecure),
    .hyp_enabled(hyp_enabled), .trap_bit(trap_bit), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd1), .undef_o(und1), .trap_o(trp1),
    .syndrome_o(syn1), .mmu_en(m1), .align_chk(a1), .dcache_en(d1),
    .icache_en(i1), .big_endian(e1));

  function automatic logic [31:0] shape(input logic [31:0] v, input logic [31:0] o,
                                        input logic [31:0] z);
    return (v & ~(o | z)) | o;
  endfunction

  function automatic string tag_of(input logic [1:0] l);
    case (l)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] l, input logic ns, input logic he,
                        input logic tb, input logic w, input logic r,
                        input logic [31:0] d);
    @(negedge clk);
    level = l; nonsecure = ns; hyp_enabled = he; trap_bit = tb;
    wr_en = w; rd_en = r; wr_data = d;
    #2;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(64'd20 * 200000);
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] pa, pb, held0, held1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset contents, read from hypervisor level
    access(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R3", rd0, 32'h30C5_0818);
    chk("R3", rd1, 32'h30C5_0838);
    chk("R3", {27'd0, m0, a0, d0, i0, e0}, 32'd0);
    // R9: idle produces no flags and zero read data
    access(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R9", {rd0[31:2], und0, trp0}, 32'd0);

    for (int c = 0; c < 32; c++) begin
      logic [1:0] l;
      logic ns, he, tb, ex_u, ex_t, ok;
      l = c[4:3]; ns = c[2]; he = c[1]; tb = c[0];
      ex_t = (l == 2'd1) && he && tb;
      ex_u = (l == 2'd0) || ((l == 2'd1) && !ex_t) || ((l == 2'd3) && !ns);
      ok = !ex_u && !ex_t;
      pa = 32'h1357_9BDF ^ (32'(c) * 32'h0101_0303);
      pb = ~pa ^ (32'(c) << 7);
      // preload through the hypervisor level (R6)
      access(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, pa);
      chk("R6", {30'd0, und0, trp0}, 32'd0);
      // write attempt under the swept combination
      access(l, ns, he, tb, 1'b1, 1'b0, pb);
      chk(tag_of(l), {24'd0, und0, trp0, syn0}, {24'd0, ex_u, ex_t, ex_t ? 6'd3 : 6'd0});
      chk(tag_of(l), {30'd0, und1, trp1}, {30'd0, ex_u, ex_t});
      // read back through the hypervisor level
      held0 = shape(ok ? pb : pa, ONE_A, ZERO_A);
      held1 = shape(ok ? pb : pa, ONE_B, ZERO_B);
      access(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
      chk(ok ? "R1" : "R9", rd0, held0);
      chk(ok ? "R2" : "R9", rd1, held1);
      chk("R8", {30'd0, rd0[7], rd0[5]}, {30'd0, held0[7], held0[5]});
      chk("R10", {27'd0, m0, a0, d0, i0, e0},
          {27'd0, held0[0], held0[1], held0[2], held0[12], held0[25]});
      chk("R10", {27'd0, m1, a1, d1, i1, e1},
          {27'd0, held1[0], held1[1], held1[2], held1[12], held1[25]});
      // read attempt under the swept combination
      access(l, ns, he, tb, 1'b0, 1'b1, '0);
      chk(tag_of(l), rd0, ok ? held0 : 32'd0);
      chk(ok ? tag_of(l) : "R9", rd1, ok ? held1 : 32'd0);
    end

    // R1/R2: all-ones and all-zeros writes from hypervisor level
    access(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    access(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R2", rd0, ~ZERO_A);
    chk("R2", rd1, ~ZERO_B);
    access(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    access(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R1", rd0, ONE_A);
    chk("R1", rd1, ONE_B);
    // R6: read and write in the same cycle return the old word
    access(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0200_1007);
    chk("R6", rd0, ONE_A);
    access(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R6", rd0, ONE_A | 32'h0200_1007);
    access(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    summary();
  end
endmodule